// File: doc/BRIEF.md
# Bit-Field Extract Unit

This integer execution unit pulls a contiguous run of bits out of a source operand and returns it zero-extended. One control word carries two unsigned 8-bit fields: where the field starts and how many bits it spans. A size select picks 32-bit or 64-bit operation. The unit also produces logical-style arithmetic flags for the result. Each flag sits at a fixed bit position in the flag vector.

The start field and the length field are each checked on their own against the largest bit index of the chosen size. That index is 31 in 32-bit mode and 63 in 64-bit mode. A start past that index yields zero. A length past it leaves the shifted value unmasked. A length of zero always yields zero. The result can pass straight through or go through one output register stage. Results leave in issue order.

Top module: `bfx_unit`

## Requirements
- R1: The start position is taken from control bits 7:0 and the length from control bits 15:8. Control bits above 15 have no effect on the result or the flags.
- R2: With `wide_i`=1 (64-bit), the result is the source shifted right by the start position. Every bit at index length and above is then cleared.
- R3: With `wide_i`=0 (32-bit), only source bits 31:0 take part. Result bits 63:32 are always zero.
- R4: When the start position is greater than the size bound (31 for 32-bit, 63 for 64-bit), the result is zero.
- R5: When the length is greater than the size bound, no bits are cleared and the whole shifted value is returned.
- R6: A length of zero gives a zero result, whatever the source and start values.
- R7: Flag bit 2 (zero) is 1 exactly when the result is zero.
- R8: Flag bit 0 (carry) and flag bit 4 (overflow) are always 0.
- R9: Flag bit 3 (sign) equals result bit 63 in 64-bit mode and result bit 31 in 32-bit mode. Flag bit 1 (parity) is 1 when result bits 7:0 hold an even number of ones.
- R10: With the output register enabled, `valid_o` follows `valid_i` exactly one cycle later and carries that cycle's result. Reset forces `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| wide_i | input | 1 | Operand size: 1 = 64-bit, 0 = 32-bit |
| src_i | input | XLEN | Source operand |
| ctrl_i | input | CTRL_W | Control word: start in 7:0, length in 15:8 |
| valid_o | output | 1 | Result valid |
| result_o | output | XLEN | Zero-extended extracted field |
| flags_o | output | 5 | {overflow, sign, zero, parity, carry} |

## Verification
The hardest cases to reach are the ones where a field value lies just past the size bound but its low six bits look like a legal shift. A start of 64 in 64-bit mode, or of 32 in 32-bit mode, would shift by zero if the range check were missing. The length field has the same trap. To cover these, the stimulus sweeps every start and every length from 0 to 255 in both sizes. Each operation uses a random source and random upper control bits. Every result is compared with a bit-by-bit model in the bench, after a table of fixed corner vectors.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int unsigned FIELD_W   = 8;
  localparam int unsigned START_LSB = 0;
  localparam int unsigned LEN_LSB   = 8;
  localparam int unsigned NFLAGS    = 5;

  // bit order: of=4 sf=3 zf=2 pf=1 cf=0
  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic pf_f;
    logic cf_f;
  } flags_t;
endpackage

// File: rtl/bfx_align.sv
module bfx_align #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32,
  parameter int unsigned FW     = 8
) (
  input  logic              wide_i,
  input  logic [FW-1:0]     bound_i,
  input  logic [FW-1:0]     start_i,
  input  logic [XLEN-1:0]   src_i,
  output logic [XLEN-1:0]   shifted_o
);
  localparam int unsigned SH_W = $clog2(XLEN);
  localparam logic [XLEN-1:0] NARROW_MASK = {{(XLEN-NARROW){1'b0}}, {NARROW{1'b1}}};

  logic [XLEN-1:0] opnd;

  // narrow operands drop upper source bits before the shift
  assign opnd      = wide_i ? src_i : (src_i & NARROW_MASK);
  assign shifted_o = (start_i <= bound_i) ? (opnd >> start_i[SH_W-1:0]) : '0;
endmodule

// File: rtl/bfx_trim.sv
module bfx_trim #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned FW   = 8
) (
  input  logic [FW-1:0]   bound_i,
  input  logic [FW-1:0]   len_i,
  input  logic [XLEN-1:0] data_i,
  output logic [XLEN-1:0] data_o
);
  localparam int unsigned SH_W = $clog2(XLEN);

  logic [XLEN-1:0] clear_mask;

  // oversized length clears nothing; zero length clears all
  assign clear_mask = (len_i > bound_i) ? '0 : ({XLEN{1'b1}} << len_i[SH_W-1:0]);
  assign data_o     = data_i & ~clear_mask;
endmodule

// File: rtl/bfx_flags.sv
module bfx_flags
  import bfx_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32
) (
  input  logic            wide_i,
  input  logic [XLEN-1:0] res_i,
  output flags_t          flags_o
);
  always_comb begin
    flags_o      = '0;
    flags_o.zf_f = ~|res_i;
    flags_o.sf_f = wide_i ? res_i[XLEN-1] : res_i[NARROW-1];
    flags_o.pf_f = ~^res_i[7:0];
    flags_o.cf_f = 1'b0;
    flags_o.of_f = 1'b0;
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NARROW  = 32,
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned OUT_REG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              wide_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              valid_o,
  output logic [XLEN-1:0]   result_o,
  output logic [NFLAGS-1:0] flags_o
);
  localparam int unsigned FW     = FIELD_W;
  localparam int unsigned CTRL_U = LEN_LSB + FW;

  logic [FW-1:0]   start_w, len_w, bound_w;
  logic [XLEN-1:0] shifted_w, res_d;
  flags_t          flags_d;

  assign start_w = ctrl_i[START_LSB +: FW];
  assign len_w   = ctrl_i[LEN_LSB +: FW];
  assign bound_w = wide_i ? FW'(XLEN-1) : FW'(NARROW-1);

  generate
    if (CTRL_W > CTRL_U) begin : g_ctrl_hi
      logic unused_ctrl_hi;
      assign unused_ctrl_hi = ^ctrl_i[CTRL_W-1:CTRL_U];
    end
  endgenerate

  bfx_align #(.XLEN(XLEN), .NARROW(NARROW), .FW(FW)) u_align (
    .wide_i   (wide_i),
    .bound_i  (bound_w),
    .start_i  (start_w),
    .src_i    (src_i),
    .shifted_o(shifted_w)
  );

  bfx_trim #(.XLEN(XLEN), .FW(FW)) u_trim (
    .bound_i(bound_w),
    .len_i  (len_w),
    .data_i (shifted_w),
    .data_o (res_d)
  );

  bfx_flags #(.XLEN(XLEN), .NARROW(NARROW)) u_flags (
    .wide_i (wide_i),
    .res_i  (res_d),
    .flags_o(flags_d)
  );

  generate
    if (OUT_REG != 0) begin : g_reg
      logic            valid_q;
      logic [XLEN-1:0] res_q;
      flags_t          flags_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_q <= 1'b0;
          res_q   <= '0;
          flags_q <= '0;
        end else begin
          valid_q <= valid_i;
          if (valid_i) begin
            res_q   <= res_d;
            flags_q <= flags_d;
          end
        end
      end

      assign valid_o  = valid_q;
      assign result_o = res_q;
      assign flags_o  = flags_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign valid_o  = valid_i;
      assign result_o = res_d;
      assign flags_o  = flags_d;
    end
  endgenerate
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NARROW  = 32,
  parameter int unsigned OUT_REG = 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            wide_i,
  input logic [15:0]     ctrl_i,
  input logic [XLEN-1:0] res_d,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic [4:0]      flags_o
);
  logic [7:0] bound;
  assign bound = wide_i ? 8'(XLEN-1) : 8'(NARROW-1);

  a_r6_len_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i[15:8] == 8'd0) |-> (res_d == '0));

  a_r4_start_oob: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i[7:0] > bound) |-> (res_d == '0));

  a_r3_narrow_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |-> (res_d[XLEN-1:NARROW] == '0));

  a_r8_cf_of_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!flags_o[0] && !flags_o[4]));

  a_r7_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flags_o[2] == (result_o == '0)));

  generate
    if (OUT_REG != 0) begin : g_lat
      a_r10_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);
      a_r10_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o);
    end
  endgenerate
endmodule

bind bfx_unit bfx_unit_chk #(.XLEN(XLEN), .NARROW(NARROW), .OUT_REG(OUT_REG)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .wide_i  (wide_i),
  .ctrl_i  (ctrl_i[15:0]),
  .res_d   (res_d),
  .valid_o (valid_o),
  .result_o(result_o),
  .flags_o (flags_o)
);

// File: tb/tb_bfx_unit.sv
`timescale 1ns/1ps
module tb_bfx_unit;
  localparam int NV = 9;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [63:0] src_i = '0;
  logic [31:0] ctrl_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [4:0]  flags_o;

  int n_chk = 0;
  int n_fail = 0;

  logic        pend = 1'b0;
  logic [63:0] exp_res;
  logic [4:0]  exp_flg;
  string       exp_tag;

  localparam logic        V_WIDE [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [63:0] V_SRC  [NV] = '{
    64'hFEDCBA9876543210, 64'hFEDCBA9876543210, 64'h8F635A775AD3B9B4,
    64'hFFFFFFFFFFFFFFFF, 64'hFEDCBA9876543210, 64'h0123456789ABCDEF,
    64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000};
  localparam logic [31:0] V_CTRL [NV] = '{
    32'h7F00, 32'h7F00, 32'h3018, 32'h0000, 32'h10F8,
    32'hFFFF0810, 32'h4000, 32'h201F, 32'h013F};
  localparam logic [63:0] V_EXP  [NV] = '{
    64'hFEDCBA9876543210, 64'h76543210, 64'h5A, 64'h0, 64'h0,
    64'hAB, 64'hFFFFFFFFFFFFFFFF, 64'h1, 64'h1};

  bfx_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .wide_i(wide_i),
    .src_i(src_i), .ctrl_i(ctrl_i), .valid_o(valid_o), .result_o(result_o),
    .flags_o(flags_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic logic [63:0] ref_res(logic w, logic [63:0] s, logic [31:0] c);
    int st = int'(c[7:0]);
    int ln = int'(c[15:8]);
    int width = w ? 64 : 32;
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++)
      if (i < width && i < ln && st + i < width) r[i] = s[st+i];
    return r;
  endfunction

  function automatic logic [4:0] ref_flg(logic w, logic [63:0] r);
    logic sf = w ? r[63] : r[31];
    return {1'b0, sf, (r == 64'd0), ~^r[7:0], 1'b0};
  endfunction

  function automatic string pick_tag(logic w, logic [31:0] c);
    int bnd = w ? 63 : 31;
    if (c[15:8] == 0) return "R6";
    if (int'(c[7:0]) > bnd) return "R4";
    if (int'(c[15:8]) > bnd) return "R5";
    if (!w) return "R3";
    return "R2";
  endfunction

  task automatic check_out();
    n_chk++;
    if (pend) begin
      if (!valid_o) begin
        n_fail++;
        $display("FAIL R10 valid_o act=%0b exp=1", valid_o);
      end
      n_chk++;
      if (result_o !== exp_res) begin
        n_fail++;
        $display("FAIL %s result act=%h exp=%h", exp_tag, result_o, exp_res);
      end
      n_chk++;
      if (flags_o !== exp_flg) begin
        n_fail++;
        $display("FAIL R7 R8 R9 flags act=%b exp=%b", flags_o, exp_flg);
      end
    end else if (valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 idle valid_o act=%0b exp=0", valid_o);
    end
  endtask

  task automatic issue(logic w, logic [63:0] s, logic [31:0] c, logic [63:0] e, string tag);
    @(negedge clk_i);
    check_out();
    valid_i = 1'b1; wide_i = w; src_i = s; ctrl_i = c;
    pend = 1'b1; exp_res = e; exp_flg = ref_flg(w, e); exp_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk_i);
    check_out();
    valid_i = 1'b0;
    pend = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    // R10: reset holds valid_o low even with valid_i high
    valid_i = 1'b1; wide_i = 1'b1; src_i = '1; ctrl_i = 32'h4000;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b0 || result_o !== 64'd0) begin
      n_fail++;
      $display("FAIL R10 reset act=%0b/%h exp=0/0", valid_o, result_o);
    end
    valid_i = 1'b0;
    rst_ni = 1'b1;

    // table: R1 R2 R3 R4 R5 R6 corner vectors
    for (int k = 0; k < NV; k++) begin
      issue(V_WIDE[k], V_SRC[k], V_CTRL[k], V_EXP[k], (k == 5) ? "R1" : pick_tag(V_WIDE[k], V_CTRL[k]));
      n_chk++;
      if (ref_res(V_WIDE[k], V_SRC[k], V_CTRL[k]) !== V_EXP[k]) begin
        n_fail++;
        $display("FAIL R2 model act=%h exp=%h", ref_res(V_WIDE[k], V_SRC[k], V_CTRL[k]), V_EXP[k]);
      end
    end
    idle();
    idle();

    // R1: same fields, different upper control bits, same result
    issue(1'b1, 64'h0123456789ABCDEF, 32'h00000810, 64'hAB, "R1");
    issue(1'b1, 64'h0123456789ABCDEF, 32'hA5A50810, 64'hAB, "R1");
    idle();

    // R10: reset asserted while an op is in flight drops it
    issue(1'b1, 64'h1234, 32'h0800, 64'h34, "R2");
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 mid reset act=%0b exp=0", valid_o);
    end
    valid_i = 1'b0; pend = 1'b0;
    rst_ni = 1'b1;
    idle();

    // full sweep of start and length in both sizes
    for (int w = 0; w < 2; w++)
      for (int ln = 0; ln < 256; ln++)
        for (int st = 0; st < 256; st++) begin
          logic [63:0] s = {$urandom(), $urandom()};
          logic [31:0] c = {16'($urandom()), 8'(ln), 8'(st)};
          issue(w[0], s, c, ref_res(w[0], s, c), pick_tag(w[0], c));
        end
    idle();
    idle();
    finish_run();
  end
endmodule